// File: doc/BRIEF.md
# Test Pattern Injection Response Checker

This block runs one test cycle against a channel of combinational safety logic. On a start request it captures a test pattern and an expected result, then drives a test strobe of fixed, bounded width. While the strobe is high the logic's live inputs are meant to be blocked, and the captured pattern bits are driven onto a separate test-data path that is OR-combined into the logic. While the strobe is high the block samples the logic's output on every clock. It records whether the expected value first appeared inside the response window, later than the window, or not at all.

A second timer runs on an independent clock and counts how long it sees the strobe high. The timer returns an in-range or out-of-range verdict to the main clock domain through two-flop synchronisers and a four-phase request/acknowledge handshake. Any timing disagreement, missing verdict, wrong output or late response halts the sequencer. The halt latches a general fault flag and a fault code. A fault in the logic under test also raises a second indication that carries the system and division identifiers. The faults are released only by an explicit reinitialise.

All pins are plain control and status levels. No data stream crosses the block, so there is no valid/ready interface and no back-pressure.

Top module: `test_inject_checker`

## Requirements
- R1: After reset, strobe, test data, busy, done, fault flag, logic-fault indication and identifier outputs are all low, and the fault code is NONE (0).
- R2: A start request sampled while the block is idle and unfaulted raises the strobe on the next clock. The strobe stays high for exactly STROBE_CYC clocks and never longer.
- R3: While the strobe is high the test-data output equals the pattern captured at start. While the strobe is low the test-data output is all zeros.
- R4: Number the clock edges of the strobe from k = 0. If the observed output equals the expected value at some edge with k < WIN_CYC and the watchdog verdict is in range, the test passes: done pulses for one clock and no fault is raised.
- R5: If the first match occurs at an edge with k >= WIN_CYC, the block faults with code LATE (3).
- R6: If no match occurs while the strobe is high, the block faults with code WRONG (2).
- R7: The watchdog counts independent-clock edges while it sees the strobe high. If the count lies outside WD_EXP ± WD_TOL, the block faults with code TIMING (1).
- R8: If no watchdog verdict completes within WD_WAIT_MAX clocks after the strobe falls, the block faults with code TIMING (1).
- R9: Any fault sets the general fault flag. Codes WRONG and LATE also set the logic-fault indication and drive SYS_ID and DIV_ID on the identifier outputs. Code TIMING leaves these low. A timing failure takes priority over a response failure.
- R10: A latched fault and its code hold until reinitialise. A start request while a fault is latched is ignored and produces no strobe.
- R11: Reinitialise while faulted clears the fault flag, code, logic indication and identifiers, and returns the block to idle, ready for a new start.
- R12: The watchdog request stays high until it sees the acknowledge. The acknowledge rises only in answer to a synchronised request. Back-to-back tests complete once the handshake has returned to rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main sequencer clock |
| rst_n | input | 1 | Active-low reset, main domain |
| wd_clk | input | 1 | Independent watchdog clock |
| wd_rst_n | input | 1 | Active-low reset, watchdog domain |
| start | input | 1 | Request to run one test cycle |
| reinit | input | 1 | Clears latched faults when halted |
| pattern | input | N_IN | Test pattern register value |
| expected | input | N_OUT | Expected logic output |
| obs | input | N_OUT | Observed output of the logic under test |
| strobe | output | 1 | Test strobe; blocks the live inputs while high |
| tdat | output | N_IN | Test data for the OR-combined alternate inputs |
| busy | output | 1 | A test cycle is in progress |
| done | output | 1 | One-clock pulse on a passing test |
| fault_any | output | 1 | Latched general fault |
| fault_logic | output | 1 | Latched fault located in the logic under test |
| fault_code | output | 2 | 0 NONE, 1 TIMING, 2 WRONG, 3 LATE |
| fault_sys | output | SYS_W | System identifier while fault_logic is set |
| fault_div | output | DIV_W | Division identifier while fault_logic is set |

## Verification
The assertions assume that pattern and expected stay steady for the clock in which start is sampled. They also assume the independent clock is either stopped or fast enough that the strobe is seen and the handshake is answered. Finally, they assume reinit is a request and not a level held through a whole test. The bench changes pattern, expected and the logic model only at falling edges, pulses start and reinit for one clock, and lets the delay line of the logic model refill with the live value before each start. That way no pre-strobe value can match by accident. The independent clock is stopped only while no strobe is in flight, and it is restarted only after the resulting fault has latched.

// File: rtl/tic_pkg.sv
package tic_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TIMING = 2'd1,
    FLT_WRONG  = 2'd2,
    FLT_LATE   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_STRB = 3'd1,
    ST_WDW  = 3'd2,
    ST_ACKW = 3'd3,
    ST_HALT = 3'd4
  } state_e;

endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/tic_wd.sv
module tic_wd #(
  parameter int WD_EXP = 8,
  parameter int WD_TOL = 2
) (
  input  logic wd_clk,
  input  logic wd_rst_n,
  input  logic strobe_async,
  input  logic ack_async,
  output logic req,
  output logic ok
);
  localparam int HI   = WD_EXP + WD_TOL;
  localparam int LO   = (WD_EXP > WD_TOL) ? (WD_EXP - WD_TOL) : 0;
  localparam int CW   = $clog2(HI + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          strb_s, ack_s, strb_d;
  logic [CW-1:0] cnt;

  tic_sync #(.W(1)) u_strb (.clk(wd_clk), .rst_n(wd_rst_n), .d(strobe_async), .q(strb_s));
  tic_sync #(.W(1)) u_ack  (.clk(wd_clk), .rst_n(wd_rst_n), .d(ack_async),    .q(ack_s));

  function automatic logic in_range(input logic [CW-1:0] c);
    return (int'(c) >= LO) && (int'(c) <= HI);
  endfunction

  always_ff @(posedge wd_clk or negedge wd_rst_n) begin
    if (!wd_rst_n) begin
      strb_d <= 1'b0;
      cnt    <= '0;
      req    <= 1'b0;
      ok     <= 1'b0;
    end else begin
      strb_d <= strb_s;
      if (strb_s && !strb_d)
        cnt <= CW'(1);
      else if (strb_s && cnt != CMAX)
        cnt <= cnt + 1'b1;
      if (!strb_s && strb_d) begin
        req <= 1'b1;
        ok  <= in_range(cnt);
      end else if (req && ack_s) begin
        req <= 1'b0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (req && !ack_s) |=> req); // R12
  AST_OK_HELD: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
    (req && !ack_s) |=> $stable(ok)); // R12
endmodule

// File: rtl/tic_resp.sv
module tic_resp #(
  parameter int N_OUT   = 4,
  parameter int CNT_W   = 5,
  parameter int WIN_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic [CNT_W-1:0] idx,
  input  logic [N_OUT-1:0] obs,
  input  logic [N_OUT-1:0] exp_v,
  output logic             hit_early,
  output logic             hit_late
);
  localparam logic [CNT_W-1:0] WIN = CNT_W'(WIN_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_early <= 1'b0;
      hit_late  <= 1'b0;
    end else if (clear) begin
      hit_early <= 1'b0;
      hit_late  <= 1'b0;
    end else if (active && (obs == exp_v) && !hit_early && !hit_late) begin
      if (idx < WIN) hit_early <= 1'b1;
      else           hit_late  <= 1'b1;
    end
  end

  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable({hit_early, hit_late})); // R4
endmodule

// File: rtl/tic_seq.sv
module tic_seq
  import tic_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int N_OUT       = 4,
  parameter int STROBE_CYC  = 20,
  parameter int WIN_CYC     = 8,
  parameter int WD_WAIT_MAX = 64,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reinit,
  input  logic [N_IN-1:0]  pattern,
  input  logic [N_OUT-1:0] expected,
  input  logic             req_s,
  input  logic             ok_s,
  input  logic             hit_early,
  input  logic             hit_late,
  output logic             strb_on,
  output logic             clear_resp,
  output logic [CNT_W-1:0] idx,
  output logic [N_IN-1:0]  pat_q,
  output logic [N_OUT-1:0] exp_q,
  output logic             ack,
  output logic             busy,
  output logic             done,
  output logic             fault_any,
  output logic             fault_logic,
  output fault_e           fault_code
);
  localparam int TW = $clog2(WD_WAIT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [TW-1:0]    TLIM = TW'(WD_WAIT_MAX - 1);

  state_e        state;
  logic [TW-1:0] wdt;

  assign strb_on    = (state == ST_STRB);
  assign busy       = (state == ST_STRB) || (state == ST_WDW) || (state == ST_ACKW);
  assign clear_resp = (state == ST_IDLE) && start;

  function automatic fault_e verdict(input logic okv, input logic he, input logic hl);
    if (!okv)    return FLT_TIMING;
    else if (he) return FLT_NONE;
    else if (hl) return FLT_LATE;
    else         return FLT_WRONG;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      wdt         <= '0;
      pat_q       <= '0;
      exp_q       <= '0;
      ack         <= 1'b0;
      done        <= 1'b0;
      fault_any   <= 1'b0;
      fault_logic <= 1'b0;
      fault_code  <= FLT_NONE;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pat_q <= pattern;
            exp_q <= expected;
            idx   <= '0;
            state <= ST_STRB;
          end
        end
        ST_STRB: begin
          idx <= idx + 1'b1;
          if (idx == LAST) begin
            wdt   <= '0;
            state <= ST_WDW;
          end
        end
        ST_WDW: begin
          wdt <= wdt + 1'b1;
          if (req_s) begin
            ack   <= 1'b1;
            state <= ST_ACKW;
          end else if (wdt == TLIM) begin
            fault_any  <= 1'b1;
            fault_code <= FLT_TIMING;
            state      <= ST_HALT;
          end
        end
        ST_ACKW: begin
          wdt <= wdt + 1'b1;
          if (!req_s) begin
            ack <= 1'b0;
            if (verdict(ok_s, hit_early, hit_late) == FLT_NONE) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              fault_any   <= 1'b1;
              fault_code  <= verdict(ok_s, hit_early, hit_late);
              fault_logic <= (verdict(ok_s, hit_early, hit_late) != FLT_TIMING);
              state       <= ST_HALT;
            end
          end else if (wdt == TLIM) begin
            ack        <= 1'b0;
            fault_any  <= 1'b1;
            fault_code <= FLT_TIMING;
            state      <= ST_HALT;
          end
        end
        ST_HALT: begin
          if (reinit) begin
            fault_any   <= 1'b0;
            fault_logic <= 1'b0;
            fault_code  <= FLT_NONE;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !reinit) |=> fault_any); // R10
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !reinit) |=> $stable(fault_code)); // R10
  AST_NO_STROBE_FAULTED: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> !strb_on); // R10
  AST_LOGIC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_logic |-> (fault_code == FLT_WRONG || fault_code == FLT_LATE)); // R9
  AST_ACK_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req_s)); // R12
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fault_any); // R4
endmodule

// File: rtl/test_inject_checker.sv
module test_inject_checker
  import tic_pkg::*;
#(
  parameter int N_IN        = 4,
  parameter int N_OUT       = 4,
  parameter int STROBE_CYC  = 20,
  parameter int WIN_CYC     = 8,
  parameter int WD_EXP      = 8,
  parameter int WD_TOL      = 2,
  parameter int WD_WAIT_MAX = 64,
  parameter int SYS_W       = 3,
  parameter int DIV_W       = 2,
  parameter int SYS_ID      = 5,
  parameter int DIV_ID      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_clk,
  input  logic             wd_rst_n,
  input  logic             start,
  input  logic             reinit,
  input  logic [N_IN-1:0]  pattern,
  input  logic [N_OUT-1:0] expected,
  input  logic [N_OUT-1:0] obs,
  output logic             strobe,
  output logic [N_IN-1:0]  tdat,
  output logic             busy,
  output logic             done,
  output logic             fault_any,
  output logic             fault_logic,
  output logic [1:0]       fault_code,
  output logic [SYS_W-1:0] fault_sys,
  output logic [DIV_W-1:0] fault_div
);
  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  logic             strb_on, clear_resp, ack, req_w, ok_w, req_s, ok_s;
  logic             hit_early, hit_late;
  logic [CNT_W-1:0] idx;
  logic [N_IN-1:0]  pat_q;
  logic [N_OUT-1:0] exp_q;
  fault_e           code;

  tic_seq #(
    .N_IN(N_IN), .N_OUT(N_OUT), .STROBE_CYC(STROBE_CYC), .WIN_CYC(WIN_CYC),
    .WD_WAIT_MAX(WD_WAIT_MAX), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .reinit(reinit),
    .pattern(pattern), .expected(expected), .req_s(req_s), .ok_s(ok_s),
    .hit_early(hit_early), .hit_late(hit_late), .strb_on(strb_on),
    .clear_resp(clear_resp), .idx(idx), .pat_q(pat_q), .exp_q(exp_q),
    .ack(ack), .busy(busy), .done(done), .fault_any(fault_any),
    .fault_logic(fault_logic), .fault_code(code)
  );

  tic_resp #(.N_OUT(N_OUT), .CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_resp (
    .clk(clk), .rst_n(rst_n), .clear(clear_resp), .active(strb_on),
    .idx(idx), .obs(obs), .exp_v(exp_q),
    .hit_early(hit_early), .hit_late(hit_late)
  );

  tic_wd #(.WD_EXP(WD_EXP), .WD_TOL(WD_TOL)) u_wd (
    .wd_clk(wd_clk), .wd_rst_n(wd_rst_n), .strobe_async(strb_on),
    .ack_async(ack), .req(req_w), .ok(ok_w)
  );

  tic_sync #(.W(2)) u_back (
    .clk(clk), .rst_n(rst_n), .d({req_w, ok_w}), .q({req_s, ok_s})
  );

  assign strobe     = strb_on;
  assign tdat       = strb_on ? pat_q : '0;
  assign fault_code = code;
  assign fault_sys  = fault_logic ? SYS_W'(SYS_ID) : '0;
  assign fault_div  = fault_logic ? DIV_W'(DIV_ID) : '0;

  logic [CNT_W:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (strobe) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (run_len < (CNT_W+1)'(STROBE_CYC))); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && start) |=> !strobe); // R10
endmodule

// File: tb/sim_test_inject_checker.sv
module sim_test_inject_checker;
  localparam int N = 4;
  localparam int STROBE = 20;
  localparam int SYSV = 5;
  localparam int DIVV = 2;

  logic clk = 0, wd_clk = 0, rst_n = 0, wd_rst_n = 0;
  logic start = 0, reinit = 0;
  logic [N-1:0] pattern = 0, expected = 0, live = 0, flip = 0;
  int dly = 0;
  int wd_half = 5;
  bit wd_run = 1;

  logic strobe, busy, done, fault_any, fault_logic;
  logic [N-1:0] tdat, obs, eff;
  logic [1:0] fault_code;
  logic [2:0] fault_sys;
  logic [1:0] fault_div;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;
  always begin
    #(wd_half);
    if (wd_run) wd_clk = ~wd_clk;
  end

  logic [N-1:0] sh [0:31];
  assign eff = (live & ~{N{strobe}}) | tdat;
  assign obs = ((dly == 0) ? eff : sh[dly-1]) ^ flip;
  always @(posedge clk) begin
    sh[0] <= eff;
    for (int i = 1; i < 32; i++) sh[i] <= sh[i-1];
  end

  test_inject_checker u0 (
    .clk(clk), .rst_n(rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
    .start(start), .reinit(reinit), .pattern(pattern), .expected(expected),
    .obs(obs), .strobe(strobe), .tdat(tdat), .busy(busy), .done(done),
    .fault_any(fault_any), .fault_logic(fault_logic), .fault_code(fault_code),
    .fault_sys(fault_sys), .fault_div(fault_div)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  task automatic do_reinit();
    @(negedge clk) reinit = 1;
    @(negedge clk) reinit = 0;
    @(negedge clk);
  endtask

  // Runs one test and checks width, test data, outcome and indications.
  task automatic run_case(input logic [N-1:0] p, input logic [N-1:0] e,
                          input logic [N-1:0] lv, input int d,
                          input logic [N-1:0] fl, input int code,
                          input bit clear_after);
    int sw = 0, bad = 0;
    bit got_done = 0;
    string tag;
    tag = (code == 0) ? "R4" : (code == 3) ? "R5" : (code == 2) ? "R6" : "R7";
    @(negedge clk);
    live = lv; dly = d; flip = fl;
    repeat (40) @(negedge clk);
    pattern = p; expected = e; start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 300; i++) begin
      if (strobe) begin
        sw++;
        if (tdat != p) bad++;
      end else if (tdat != 0) bad++;
      if (done) begin got_done = 1; break; end
      if (fault_any) break;
      @(negedge clk);
    end
    chk(sw == STROBE, "R2", "strobe width", sw, STROBE);
    chk(bad == 0, "R3", "test data mismatches", bad, 0);
    chk(int'(fault_code) == code, tag, "fault code", fault_code, code);
    if (code == 0) begin
      chk(got_done && !fault_any, "R4", "done without fault", got_done, 1);
    end else begin
      chk(fault_any == 1, "R9", "fault flag", fault_any, 1);
      if (code == 1) begin
        chk(fault_logic == 0 && fault_sys == 0, "R9", "no logic indication on timing",
            fault_logic, 0);
      end else begin
        chk(fault_logic == 1, "R9", "logic indication", fault_logic, 1);
        chk(fault_sys == SYSV && fault_div == DIVV, "R9", "system/division",
            {fault_sys, fault_div}, (SYSV << 2) | DIVV);
      end
      if (clear_after) begin
        do_reinit();
        chk(!fault_any && fault_code == 0 && !fault_logic, "R11", "cleared",
            fault_code, 0);
      end
    end
  endtask

  // pat, exp, live, delay, flip, expected code
  localparam logic [23:0] VEC [0:8] = '{
    {4'h5, 4'h5, 4'h0, 6'd0,  4'h0, 2'd0},
    {4'hA, 4'hA, 4'h5, 6'd3,  4'h0, 2'd0},
    {4'h3, 4'h3, 4'h0, 6'd7,  4'h0, 2'd0},
    {4'h3, 4'h3, 4'h0, 6'd8,  4'h0, 2'd3},
    {4'hC, 4'hC, 4'h0, 6'd19, 4'h0, 2'd3},
    {4'hC, 4'hC, 4'h0, 6'd25, 4'h0, 2'd2},
    {4'h6, 4'h6, 4'h0, 6'd0,  4'h1, 2'd2},
    {4'h0, 4'h0, 4'hF, 6'd2,  4'h0, 2'd0},
    {4'hF, 4'h0, 4'h0, 6'd0,  4'h0, 2'd2}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; wd_rst_n = 1;
    @(negedge clk);
    chk(!strobe && tdat == 0 && !busy && !done, "R1", "idle outputs", strobe, 0);
    chk(!fault_any && fault_code == 0 && !fault_logic && fault_sys == 0 && fault_div == 0,
        "R1", "fault outputs", fault_code, 0);

    for (int v = 0; v < 9; v++)
      run_case(VEC[v][23:20], VEC[v][19:16], VEC[v][15:12], int'(VEC[v][11:6]),
               VEC[v][5:2], int'(VEC[v][1:0]), 1'b1);

    // R12: back-to-back passing tests after the handshake rests
    run_case(4'h9, 4'h9, 4'h0, 1, 4'h0, 0, 1'b1);
    run_case(4'h7, 4'h7, 4'h0, 0, 4'h0, 0, 1'b1);
    chk(!fault_any, "R12", "consecutive handshakes complete", fault_any, 0);

    // R10: latched fault holds and blocks start
    run_case(4'h6, 4'h6, 4'h0, 0, 4'h2, 2, 1'b0);
    repeat (100) @(negedge clk);
    chk(fault_any && fault_code == 2, "R10", "fault held", fault_code, 2);
    begin
      int seen = 0;
      start = 1;
      @(negedge clk) start = 0;
      for (int i = 0; i < 30; i++) begin
        if (strobe) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R10", "start ignored while faulted", seen, 0);
      chk(fault_code == 2, "R10", "code unchanged by start", fault_code, 2);
    end
    do_reinit();
    chk(!fault_any && fault_code == 0, "R11", "reinit clears", fault_code, 0);
    run_case(4'h2, 4'h2, 4'h0, 0, 4'h0, 0, 1'b1);

    // R7: slow independent clock gives out-of-range count
    wd_half = 10;
    run_case(4'h5, 4'h5, 4'h0, 0, 4'h0, 1, 1'b1);
    // R9: timing takes priority over a wrong output
    run_case(4'h5, 4'h5, 4'h0, 0, 4'h4, 1, 1'b1);
    wd_half = 5;
    repeat (20) @(negedge clk);

    // R8: stopped independent clock gives no verdict
    wd_run = 0;
    run_case(4'h3, 4'h3, 4'h0, 0, 4'h0, 1, 1'b0);
    wd_run = 1;
    repeat (20) @(negedge clk);
    do_reinit();
    chk(!fault_any, "R11", "cleared after stall", fault_any, 0);
    run_case(4'hB, 4'hB, 4'h0, 2, 4'h0, 0, 1'b1);

    finish_run();
  end
endmodule